// File: doc/BRIEF.md
# DDR refresh and power-state sequencer

This block keeps a DDR SDRAM device refreshed and moves it in and out of its low-power states. It counts clocks against a refresh interval and earns one refresh credit per interval. Credits pile up in a small backlog while the command arbiter is busy. Each credit becomes a refresh request to the arbiter through a request/grant handshake. If any bank is open, a precharge-all request comes first. After a granted precharge-all the block waits out the row precharge time before it asks for the refresh. After a granted refresh it waits out the refresh cycle time.

On a sleep request the block asks for a self-refresh entry command and then drives the clock enable low. On a power-down request it drives the clock enable low directly. A wake request raises the clock enable again. While the device is in self-refresh no refresh credits are earned, and the interval count starts again from zero when self-refresh ends. Leaving self-refresh opens two holdoff windows, a short one for non-read commands and a long one for reads. The arbiter sees these windows as two permission outputs.

Top module: `ddr_refresh_pwr_seq`

## Requirements
- R1: Out of reset, and while reset is held, clock enable is high, no request is raised, urgency is low, and both permission outputs are high.
- R2: Outside self-refresh, one refresh credit is earned every REF_INTERVAL clocks, starting from reset. With banks closed and an idle sequencer, the refresh request rises REF_INTERVAL+1 cycles after reset is released, where cycle 0 is the first cycle after release.
- R3: The command code is 2'd0 for precharge-all, 2'd1 for refresh and 2'd2 for self-refresh entry. A credit is served with a refresh request when no bank is open. When a bank is open it is served with a precharge-all request first. If all banks close before that request is granted, the block switches to a refresh request.
- R4: The refresh request rises exactly T_RP cycles after the cycle in which precharge-all was granted.
- R5: In the cycle in which a refresh is granted, and for the T_RFC-1 cycles after it, non-read permission is low and no new request is raised.
- R6: Up to BACKLOG_MAX credits are held. The urgency output is high exactly while the backlog is full. Each granted refresh removes one credit.
- R7: A granted self-refresh entry drives clock enable low from the next cycle. While clock enable is low, no request is raised.
- R8: A wake request during self-refresh raises clock enable in the next cycle, cycle E. Non-read permission returns at E+T_XSNR and read permission at E+T_XSRD. The interval count restarts at E, so the next refresh request rises at E+REF_INTERVAL+1.
- R9: A power-down request in an idle state with no credit drops clock enable in the next cycle. A wake request raises it in the next cycle, and both permissions stay low for that one cycle.
- R10: Power-down also ends by itself when the backlog becomes full.
- R11: From idle, a pending credit wins over a sleep request, and a sleep request wins over a power-down request. Sleep is taken only with all banks closed.
- R12: Both permissions are low whenever the sequencer is between a granted precharge-all and the end of its refresh, is requesting self-refresh entry, or is leaving power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_open_i | input | NUM_BANKS | One bit per bank, high while that bank has a row open |
| sleep_req_i | input | 1 | Asks for self-refresh |
| pd_req_i | input | 1 | Asks for power-down |
| wake_i | input | 1 | Asks to leave self-refresh or power-down |
| cmd_gnt_i | input | 1 | Arbiter accepts the current request in this cycle |
| ref_req_o | output | 1 | Request for a command slot |
| ref_cmd_o | output | 2 | Requested command: 0 precharge-all, 1 refresh, 2 self-refresh entry |
| ref_urgent_o | output | 1 | Backlog is full; refresh must win arbitration |
| cke_o | output | 1 | Clock enable to the device |
| allow_other_o | output | 1 | Arbiter may issue non-read commands |
| allow_rd_o | output | 1 | Arbiter may issue read commands |

## Verification
The refresh path is tried in four settings: banks closed with prompt grants, a bank left open, grants withheld until the backlog saturates, and banks closing while a precharge-all is still waiting. Together these separate the direct refresh path, the precharge-first path, the fallback to a plain refresh, and the saturating backlog that drives urgency. The power paths are tried the same way. Sleep is raised together with power-down while a credit is pending, which shows the priority order. A long self-refresh stay shows that no credits are earned there, and the timing after exit shows the two holdoff windows and the restarted interval. Power-down is tried with a wake request and, separately, with no wake request at all, so the exit on a full backlog is seen on its own.

// File: rtl/ddr_rps_pkg.sv
package ddr_rps_pkg;

    typedef enum logic [1:0] {
        RPS_CMD_PREA = 2'd0,
        RPS_CMD_REF  = 2'd1,
        RPS_CMD_SRE  = 2'd2
    } rps_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRFC,
        ST_SRE,
        ST_SR,
        ST_PD,
        ST_PDX
    } rps_state_e;

endpackage

// File: rtl/rps_interval_timer.sv
module rps_interval_timer #(
    parameter int INTERVAL    = 1560,
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic clear_i,
    input  logic take_i,
    output logic pending_o,
    output logic full_o
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam int BW = $clog2(BACKLOG_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [BW-1:0] backlog;
    } tmr_t;

    tmr_t r_d, r_q;
    logic wrap;
    logic [BW-1:0] after_take;

    always_comb begin
        r_d        = r_q;
        wrap       = !hold_i && (r_q.tick == TW'(INTERVAL - 1));
        after_take = r_q.backlog - BW'(take_i);

        if (clear_i || hold_i || wrap) begin
            r_d.tick = '0;
        end else begin
            r_d.tick = r_q.tick + 1'b1;
        end

        if (clear_i) begin
            r_d.backlog = '0;
        end else if (wrap && after_take != BW'(BACKLOG_MAX)) begin
            r_d.backlog = after_take + 1'b1;
        end else begin
            r_d.backlog = after_take;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pending_o = (r_q.backlog != '0);
    assign full_o    = (r_q.backlog == BW'(BACKLOG_MAX));

endmodule

// File: rtl/rps_exit_holdoff.sv
module rps_exit_holdoff #(
    parameter int T_NONRD = 15,
    parameter int T_RD    = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic nonrd_ok_o,
    output logic rd_ok_o
);
    localparam int CW = $clog2(T_RD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(T_RD)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= CW'(T_RD);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign nonrd_ok_o = (cnt_q >= CW'(T_NONRD));
    assign rd_ok_o    = (cnt_q == CW'(T_RD));

endmodule

// File: rtl/ddr_refresh_pwr_seq.sv
module ddr_refresh_pwr_seq
    import ddr_rps_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int REF_INTERVAL = 1560,
    parameter int BACKLOG_MAX  = 8,
    parameter int T_RFC        = 14,
    parameter int T_RP         = 3,
    parameter int T_XSNR       = 15,
    parameter int T_XSRD       = 200
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 sleep_req_i,
    input  logic                 pd_req_i,
    input  logic                 wake_i,
    input  logic                 cmd_gnt_i,
    output logic                 ref_req_o,
    output logic [1:0]           ref_cmd_o,
    output logic                 ref_urgent_o,
    output logic                 cke_o,
    output logic                 allow_other_o,
    output logic                 allow_rd_o
);
    localparam int WAIT_MAX = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int WW       = $clog2(WAIT_MAX);

    typedef struct packed {
        rps_state_e    state;
        logic [WW-1:0] wait_cnt;
    } fsm_t;

    fsm_t     fsm_d, fsm_q;
    logic     any_open;
    logic     pending, full;
    logic     nonrd_ok, rd_ok;
    logic     req, ref_take, sr_enter, sr_exit;
    rps_cmd_e cmd;

    assign any_open = |bank_open_i;

    rps_interval_timer #(
        .INTERVAL    (REF_INTERVAL),
        .BACKLOG_MAX (BACKLOG_MAX)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (fsm_q.state == ST_SR),
        .clear_i   (sr_enter),
        .take_i    (ref_take),
        .pending_o (pending),
        .full_o    (full)
    );

    rps_exit_holdoff #(
        .T_NONRD (T_XSNR),
        .T_RD    (T_XSRD)
    ) i_holdoff (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (sr_exit),
        .nonrd_ok_o (nonrd_ok),
        .rd_ok_o    (rd_ok)
    );

    always_comb begin
        fsm_d    = fsm_q;
        req      = 1'b0;
        cmd      = RPS_CMD_PREA;
        ref_take = 1'b0;
        sr_enter = 1'b0;
        sr_exit  = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (nonrd_ok) begin
                    if (pending) begin
                        fsm_d.state = any_open ? ST_PRE : ST_REF;
                    end else if (sleep_req_i && !any_open) begin
                        fsm_d.state = ST_SRE;
                    end else if (pd_req_i) begin
                        fsm_d.state = ST_PD;
                    end
                end
            end
            ST_PRE: begin
                if (!any_open) begin
                    fsm_d.state = ST_REF;
                end else begin
                    req = 1'b1;
                    if (cmd_gnt_i) begin
                        fsm_d.state    = ST_TRP;
                        fsm_d.wait_cnt = WW'(T_RP - 2);
                    end
                end
            end
            ST_TRP: begin
                if (fsm_q.wait_cnt == '0) begin
                    fsm_d.state = ST_REF;
                end else begin
                    fsm_d.wait_cnt = fsm_q.wait_cnt - 1'b1;
                end
            end
            ST_REF: begin
                req = 1'b1;
                cmd = RPS_CMD_REF;
                if (cmd_gnt_i) begin
                    ref_take       = 1'b1;
                    fsm_d.state    = ST_TRFC;
                    fsm_d.wait_cnt = WW'(T_RFC - 2);
                end
            end
            ST_TRFC: begin
                if (fsm_q.wait_cnt == '0) begin
                    fsm_d.state = ST_IDLE;
                end else begin
                    fsm_d.wait_cnt = fsm_q.wait_cnt - 1'b1;
                end
            end
            ST_SRE: begin
                req = 1'b1;
                cmd = RPS_CMD_SRE;
                if (cmd_gnt_i) begin
                    sr_enter    = 1'b1;
                    fsm_d.state = ST_SR;
                end
            end
            ST_SR: begin
                if (wake_i) begin
                    sr_exit     = 1'b1;
                    fsm_d.state = ST_IDLE;
                end
            end
            ST_PD: begin
                if (wake_i || full) begin
                    fsm_d.state = ST_PDX;
                end
            end
            ST_PDX: begin
                fsm_d.state = ST_IDLE;
            end
            default: begin
                fsm_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.state    <= ST_IDLE;
            fsm_q.wait_cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    logic open_window;
    assign open_window   = (fsm_q.state == ST_IDLE) || (fsm_q.state == ST_PRE);
    assign ref_req_o     = req;
    assign ref_cmd_o     = cmd;
    assign ref_urgent_o  = full;
    assign cke_o         = !((fsm_q.state == ST_SR) || (fsm_q.state == ST_PD));
    assign allow_other_o = open_window && nonrd_ok;
    assign allow_rd_o    = open_window && rd_ok;

endmodule

// File: rtl/rps_checker.sv
module rps_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cmd_gnt_i,
    input logic       ref_req_o,
    input logic [1:0] ref_cmd_o,
    input logic       ref_urgent_o,
    input logic       cke_o,
    input logic       allow_other_o,
    input logic       allow_rd_o
);
    assert_no_req_cke_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_o |-> !ref_req_o);

    assert_sre_grant_drops_cke_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_req_o && cmd_gnt_i && ref_cmd_o == 2'd2) |=> !cke_o);

    assert_read_needs_other_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        allow_rd_o |-> allow_other_o);

    assert_refresh_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_req_o && cmd_gnt_i && ref_cmd_o == 2'd1) |=> (!ref_req_o && !allow_other_o));

    assert_prea_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_req_o && cmd_gnt_i && ref_cmd_o == 2'd0) |=> !ref_req_o);

    assert_wake_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cke_o) |-> (!allow_other_o && !allow_rd_o));

    assert_urgent_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ref_urgent_o) |-> $past(ref_req_o && cmd_gnt_i && ref_cmd_o == 2'd1));

endmodule

bind ddr_refresh_pwr_seq rps_checker i_rps_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_gnt_i     (cmd_gnt_i),
    .ref_req_o     (ref_req_o),
    .ref_cmd_o     (ref_cmd_o),
    .ref_urgent_o  (ref_urgent_o),
    .cke_o         (cke_o),
    .allow_other_o (allow_other_o),
    .allow_rd_o    (allow_rd_o)
);

// File: tb/test_ddr_refresh_pwr_seq.sv
module test_ddr_refresh_pwr_seq;
    localparam int I    = 60;
    localparam int MAXB = 8;
    localparam int TRFC = 14;
    localparam int TRP  = 3;
    localparam int TXN  = 15;
    localparam int TXR  = 200;
    localparam int NB   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          sleep_req = 1'b0, pd_req = 1'b0, wake = 1'b0, gnt_en = 1'b0;
    logic          gnt, ref_req, urgent, cke, allow_o, allow_r;
    logic [1:0]    ref_cmd;

    assign gnt = gnt_en & ref_req;
    always #10 clk = ~clk;

    ddr_refresh_pwr_seq #(
        .NUM_BANKS(NB), .REF_INTERVAL(I), .BACKLOG_MAX(MAXB), .T_RFC(TRFC),
        .T_RP(TRP), .T_XSNR(TXN), .T_XSRD(TXR)
    ) i_ddr_refresh_pwr_seq (
        .clk_i(clk), .rst_ni(rst_n), .bank_open_i(bank_open), .sleep_req_i(sleep_req),
        .pd_req_i(pd_req), .wake_i(wake), .cmd_gnt_i(gnt), .ref_req_o(ref_req),
        .ref_cmd_o(ref_cmd), .ref_urgent_o(urgent), .cke_o(cke),
        .allow_other_o(allow_o), .allow_rd_o(allow_r)
    );

    int n_checks = 0, n_fail = 0, ncyc = 0, total = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        total <= total + 1;
        if (!rst_n) ncyc <= 0; else ncyc <= ncyc + 1;
    end

    // Behavioural reference: phases with absolute deadlines.
    localparam int P_IDLE = 0, P_PRE = 1, P_PGAP = 2, P_REF = 3, P_RGAP = 4,
                   P_SRE = 5, P_SR = 6, P_PD = 7, P_PDX = 8;
    int m_phase = P_IDLE, m_credits = 0, m_age = 0, m_cyc = 0, m_exit = -100000, m_until = 0;

    function automatic bit m_req();
        return (m_phase == P_PRE && |bank_open) || m_phase == P_REF || m_phase == P_SRE;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = P_IDLE; m_credits = 0; m_age = 0; m_cyc = 0; m_exit = -100000;
        end else begin
            bit g, wrap, open;
            int nxt, c;
            g    = gnt_en && m_req();
            open = |bank_open;
            wrap = (m_phase != P_SR) && (m_age == I - 1);
            nxt  = m_phase;
            case (m_phase)
                P_IDLE: if (m_cyc - m_exit >= TXN) begin
                    if (m_credits > 0) nxt = open ? P_PRE : P_REF;
                    else if (sleep_req && !open) nxt = P_SRE;
                    else if (pd_req) nxt = P_PD;
                end
                P_PRE:  if (!open) nxt = P_REF;
                        else if (g) begin nxt = P_PGAP; m_until = m_cyc + TRP; end
                P_PGAP: if (m_cyc + 1 >= m_until) nxt = P_REF;
                P_REF:  if (g) begin nxt = P_RGAP; m_until = m_cyc + TRFC; end
                P_RGAP: if (m_cyc + 1 >= m_until) nxt = P_IDLE;
                P_SRE:  if (g) nxt = P_SR;
                P_SR:   if (wake) begin nxt = P_IDLE; m_exit = m_cyc + 1; end
                P_PD:   if (wake || m_credits == MAXB) nxt = P_PDX;
                default: nxt = P_IDLE;
            endcase
            c = m_credits;
            if (m_phase == P_REF && g) c = c - 1;
            if (wrap && c < MAXB) c = c + 1;
            if (m_phase == P_SRE && g) c = 0;
            if (m_phase == P_SR || (m_phase == P_SRE && g) || wrap) m_age = 0;
            else m_age = m_age + 1;
            m_credits = c;
            m_phase   = nxt;
            m_cyc     = m_cyc + 1;
        end
    end

    always @(negedge clk) begin
        #2;
        begin
            bit win;
            int since;
            win   = (m_phase == P_IDLE || m_phase == P_PRE);
            since = m_cyc - m_exit;
            check_eq("R7/R9 cke", int'(cke), int'(!(m_phase == P_SR || m_phase == P_PD)));
            check_eq("R2 request", int'(ref_req), int'(m_req()));
            if (m_req()) check_eq("R3 command code", int'(ref_cmd),
                                  (m_phase == P_PRE) ? 0 : (m_phase == P_REF) ? 1 : 2);
            check_eq("R6 urgency", int'(urgent), int'(m_credits == MAXB));
            check_eq("R12 non-read permission", int'(allow_o), int'(win && since >= TXN));
            check_eq("R8 read permission", int'(allow_r), int'(win && since >= TXR));
        end
    end

    always @(negedge clk) begin
        if (total > 60000) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", total, 60000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic sample();
        @(negedge clk);
        #2;
    endtask

    task automatic wait_req(output int at);
        do sample(); while (!ref_req);
        at = ncyc;
    endtask

    initial begin
        int t1, t2, t3, t4, k, te, tr;
        repeat (3) @(negedge clk);
        #2;
        check_eq("R1 cke in reset", int'(cke), 1);
        check_eq("R1 no request in reset", int'(ref_req), 0);
        check_eq("R1 permissions in reset", int'(allow_o && allow_r), 1);
        @(negedge clk); rst_n = 1'b1; gnt_en = 1'b1;
        #2;
        check_eq("R1 urgency after reset", int'(urgent), 0);

        wait_req(t1);
        check_eq("R2 first refresh cycle", t1, I + 1);
        check_eq("R3 closed banks give refresh", int'(ref_cmd), 1);
        wait_req(t2);
        check_eq("R2 refresh spacing", t2 - t1, I);

        @(negedge clk); bank_open = 4'b0010;
        wait_req(t3);
        check_eq("R3 open bank gives precharge-all", int'(ref_cmd), 0);
        wait_req(t4);
        check_eq("R3 refresh after precharge-all", int'(ref_cmd), 1);
        check_eq("R4 precharge to refresh spacing", t4 - t3, TRP);
        k = 0;
        do begin sample(); k++; end while (!allow_o);
        check_eq("R5 blocked span after refresh", k, TRFC);

        @(negedge clk); gnt_en = 1'b0;
        repeat (MAXB * I + I) @(negedge clk);
        #2;
        check_eq("R6 backlog full", int'(urgent), 1);
        check_eq("R6 precharge-all pending", int'(ref_req && ref_cmd == 2'd0), 1);
        @(negedge clk); gnt_en = 1'b1;
        repeat (6) @(negedge clk);
        #2;
        check_eq("R6 urgency drops after a grant", int'(urgent), 0);
        repeat (400) @(negedge clk);
        bank_open = '0;
        repeat (40) @(negedge clk);

        gnt_en = 1'b0; bank_open = 4'b0001;
        wait_req(t1);
        check_eq("R11 precharge-all pending", int'(ref_cmd), 0);
        @(negedge clk); sleep_req = 1'b1; pd_req = 1'b1; bank_open = '0;
        sample();
        check_eq("R3 fallback to refresh when banks close", int'(ref_req && ref_cmd == 2'd1), 1);
        check_eq("R11 refresh before sleep", int'(cke), 1);
        @(negedge clk); gnt_en = 1'b1;
        do wait_req(t2); while (ref_cmd == 2'd1);
        check_eq("R11 sleep before power-down", int'(ref_cmd), 2);
        @(negedge clk); sleep_req = 1'b0; pd_req = 1'b0;
        #2;
        check_eq("R7 cke low after entry", int'(cke), 0);
        k = 0;
        repeat (3 * I) begin sample(); if (ref_req || cke) k++; end
        check_eq("R7 quiet self-refresh", k, 0);

        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        #2;
        check_eq("R8 cke high after wake", int'(cke), 1);
        te = ncyc; tr = -1; k = 0;
        while (!allow_o) begin sample(); k++; if (ref_req && tr < 0) tr = ncyc; end
        check_eq("R8 non-read holdoff", k, TXN);
        while (!allow_r) begin sample(); k++; if (ref_req && tr < 0) tr = ncyc; end
        check_eq("R8 read holdoff", k, TXR);
        check_eq("R8 interval restarts at exit", tr - te, I + 1);

        @(negedge clk); pd_req = 1'b1;
        for (int n = 0; n < 200 && cke; n++) sample();
        check_eq("R9 power-down entered", int'(cke), 0);
        @(negedge clk); pd_req = 1'b0;
        repeat (4) @(negedge clk);
        wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        #2;
        check_eq("R9 wake raises cke", int'(cke), 1);
        check_eq("R9 exit gap blocks commands", int'(allow_o), 0);
        sample();
        check_eq("R9 commands allowed after gap", int'(allow_o), 1);

        @(negedge clk); pd_req = 1'b1;
        for (int n = 0; n < 200 && cke; n++) sample();
        @(negedge clk); pd_req = 1'b0;
        #2;
        for (int n = 0; n < MAXB * I + 100 && !cke; n++) sample();
        check_eq("R10 power-down ends on full backlog", int'(cke), 1);
        check_eq("R10 backlog full at exit", int'(urgent), 1);
        repeat (300) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule